// File: doc/BRIEF.md
# Multiband Mean and Covariance Accumulator

This block collects the first- and second-order statistics that a principal-components transform of a multi-spectral image set needs. Each input beat is one pattern vector: the pixel at a single location, taken from every spectral band. All band images must already be registered to one another. Over a frame the block keeps one running sum per band, which a later stage turns into the mean. It also keeps one running sum per distinct band pair of the product of the two pixels, which a later stage turns into the covariance.

The block never divides and never removes the mean outer product. At the end of a frame it presents the raw integer sums and the number of vectors it accepted, so that downstream logic can do the normalisation in whatever arithmetic it prefers. The covariance matrix is symmetric, so only the upper triangle, diagonal included, is accumulated. A frame opens with a start pulse and closes with the beat that carries last. Valid may drop between beats for any number of cycles, and one vector can be taken on every clock.

Top module: `mbstat_accum`

## Requirements
- R1: After a synchronous active-low reset, every band sum, every pair sum and the vector count read zero, and done_o is low.
- R2: Band b's pixel is pix_i[b*PIX_W +: PIX_W], and its sum is sum_o[b*SUM_W +: SUM_W]. The pair sums in xp_o run over the upper triangle row by row: (0,0),(0,1)..(0,D-1),(1,1),(1,2)..(D-1,D-1). Pair k sits at xp_o[k*XP_W +: XP_W], so for D=6 pair (1,1) is index 6.
- R3: Each accepted beat adds its pixel to every band sum and its pixel product x_i*x_j to every pair sum, and it increments cnt_o by one.
- R4: A cycle with vld_i low changes no sum and no count, and it never raises done_o, whatever pix_i and last_i carry.
- R5: Beats presented on consecutive clocks are all accumulated, with no cycle lost.
- R6: The beat with last_i is included in the sums. done_o is high for exactly the one cycle that begins two clock edges after that beat was presented, and in that cycle the outputs already hold the final sums and count.
- R7: While no beat is accepted and no start arrives, sum_o, xp_o and cnt_o hold their values.
- R8: A start_i pulse zeroes all sums and the count at the next edge. A beat presented together with start_i is counted as the first vector of the new frame.
- R9: A start_i in the cycle right after a last beat discards that in-flight beat, and done_o does not rise for it.
- R10: With 7-bit pixels at full scale (127 in every band) over 4096 beats, every sum is exact: band sums read 520192 and pair sums read 66064384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Opens a frame and clears all sums |
| vld_i | input | 1 | A pattern vector is present on pix_i |
| last_i | input | 1 | Marks the final vector of the frame (only meaningful with vld_i) |
| pix_i | input | BANDS*PIX_W | One unsigned pixel per band, band 0 in the low bits |
| sum_o | output | BANDS*SUM_W | Per-band running sums |
| xp_o | output | NPAIR*XP_W | Upper-triangle product sums, row-major |
| cnt_o | output | CNT_W | Number of accepted vectors since the last start |
| done_o | output | 1 | One-cycle strobe: the frame's sums are final |

## Verification
A start pulse can land in the very cycle in which done_o is high for the previous frame. The same edge must then expose the finished sums, clear them and take the start beat as the first vector of the new frame. The bench drives start with a beat exactly in the done cycle and checks the old totals before that edge. Afterwards it checks a count of one and the new beat's values. A second case places start one cycle after last, so that the clear and the in-flight beat meet at the same edge. There the bench expects no done strobe and a zero count.

// File: rtl/mbstat_pkg.sv
// Package: shared helpers for the multiband statistics accumulator.
// Assumes the band count is small, so triangular indexing is computed at
// elaboration time.
package mbstat_pkg;

    // Number of distinct (i<=j) band pairs for n bands.
    function automatic int num_pairs(input int n);
        return (n * (n + 1)) / 2;
    endfunction

    // Flat index of the first pair in triangle row 'row' for n bands.
    function automatic int row_base(input int row, input int n);
        return row * n - (row * (row - 1)) / 2;
    endfunction

    // Flat index of pair (row, col), col >= row.
    function automatic int pair_index(input int row, input int col, input int n);
        return row_base(row, n) + (col - row);
    endfunction

endpackage

// File: rtl/mbstat_prod.sv
// Module: input capture and product stage.
// Registers every incoming beat once: the band pixels, all upper-triangle
// pixel products, and the valid/last qualifiers. Assumes unsigned pixels.
// This register breaks the multiplier path away from the adders that follow.
module mbstat_prod
    import mbstat_pkg::*;
#(
    parameter int BANDS = 6,
    parameter int PIX_W = 7,
    localparam int NPAIR  = num_pairs(BANDS),
    localparam int PROD_W = 2 * PIX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic                     last_i,
    input  logic [BANDS*PIX_W-1:0]   pix_i,
    output logic                     vld_o,
    output logic                     last_o,
    output logic [BANDS*PIX_W-1:0]   pix_o,
    output logic [NPAIR*PROD_W-1:0]  prod_o
);

    // Qualifier register: last only counts when the beat is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            last_o <= 1'b0;
        end else begin
            vld_o  <= vld_i;
            last_o <= vld_i & last_i;
        end
    end

    // Pixel register: loaded only on valid beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o <= '0;
        end else if (vld_i) begin
            pix_o <= pix_i;
        end
    end

    // One multiplier per upper-triangle pair.
    for (genvar gi = 0; gi < BANDS; gi++) begin : g_row
        for (genvar gj = gi; gj < BANDS; gj++) begin : g_col
            localparam int K = pair_index(gi, gj, BANDS);
            logic [PROD_W-1:0] op_a;
            logic [PROD_W-1:0] op_b;
            logic [PROD_W-1:0] prod_q;

            assign op_a = PROD_W'(pix_i[gi*PIX_W +: PIX_W]);
            assign op_b = PROD_W'(pix_i[gj*PIX_W +: PIX_W]);

            // Product register for pair (gi, gj).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prod_q <= '0;
                end else if (vld_i) begin
                    prod_q <= op_a * op_b;
                end
            end

            assign prod_o[K*PROD_W +: PROD_W] = prod_q;
        end
    end

endmodule

// File: rtl/mbstat_acc.sv
// Module: one clearable accumulator.
// Adds a zero-extended addend when enabled. A clear has priority over an add
// on the same edge. Assumes W is wide enough for the frame, so no saturation.
module mbstat_acc #(
    parameter int W    = 26,
    parameter int IN_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            add_i,
    input  logic [IN_W-1:0] val_i,
    output logic [W-1:0]    acc_o
);

    logic [W-1:0] addend;
    assign addend = W'(val_i);

    // Running sum register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clr_i) begin
            acc_o <= '0;
        end else if (add_i) begin
            acc_o <= acc_o + addend;
        end
    end

endmodule

// File: rtl/mbstat_ctrl.sv
// Module: frame control.
// Counts the accepted vectors and raises the end-of-frame strobe one edge
// after the last beat leaves the product stage. A start at that same edge
// drops the in-flight beat and cancels the strobe.
module mbstat_ctrl #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             vld_i,
    input  logic             last_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    // Vector counter, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (start_i) begin
            cnt_o <= '0;
        end else if (vld_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // End-of-frame strobe, one cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else begin
            done_o <= vld_i & last_i & ~start_i;
        end
    end

endmodule

// File: rtl/mbstat_accum.sv
// Module: multiband mean and covariance accumulator (top).
// Takes one co-registered pattern vector per clock. It keeps per-band sums and
// upper-triangle product sums as unnormalised integers, plus a vector count.
// Assumes the caller keeps frames within the counter and sum widths.
module mbstat_accum
    import mbstat_pkg::*;
#(
    parameter int BANDS = 6,
    parameter int PIX_W = 7,
    parameter int SUM_W = 26,
    parameter int XP_W  = 34,
    parameter int CNT_W = 19,
    localparam int NPAIR  = num_pairs(BANDS),
    localparam int PROD_W = 2 * PIX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    vld_i,
    input  logic                    last_i,
    input  logic [BANDS*PIX_W-1:0]  pix_i,
    output logic [BANDS*SUM_W-1:0]  sum_o,
    output logic [NPAIR*XP_W-1:0]   xp_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    done_o
);

    logic                    vld_a;
    logic                    last_a;
    logic [BANDS*PIX_W-1:0]  pix_a;
    logic [NPAIR*PROD_W-1:0] prod_a;

    // Stage A: capture and multiply.
    mbstat_prod #(
        .BANDS (BANDS),
        .PIX_W (PIX_W)
    ) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_i),
        .last_i (last_i),
        .pix_i  (pix_i),
        .vld_o  (vld_a),
        .last_o (last_a),
        .pix_o  (pix_a),
        .prod_o (prod_a)
    );

    // Stage B: per-band sums.
    for (genvar gb = 0; gb < BANDS; gb++) begin : g_band
        mbstat_acc #(
            .W    (SUM_W),
            .IN_W (PIX_W)
        ) u_sum (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (start_i),
            .add_i (vld_a),
            .val_i (pix_a[gb*PIX_W +: PIX_W]),
            .acc_o (sum_o[gb*SUM_W +: SUM_W])
        );
    end

    // Stage B: upper-triangle product sums.
    for (genvar gk = 0; gk < NPAIR; gk++) begin : g_pair
        mbstat_acc #(
            .W    (XP_W),
            .IN_W (PROD_W)
        ) u_xp (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (start_i),
            .add_i (vld_a),
            .val_i (prod_a[gk*PROD_W +: PROD_W]),
            .acc_o (xp_o[gk*XP_W +: XP_W])
        );
    end

    // Count and end-of-frame strobe.
    mbstat_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .vld_i   (vld_a),
        .last_i  (last_a),
        .cnt_o   (cnt_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/mbstat_accum_chk.sv
// Module: port-level checker for mbstat_accum, attached with bind.
// Relates the inputs to the outputs across the two-edge pipeline. A small
// age counter keeps two-cycle lookbacks inside the time since reset.
module mbstat_accum_chk #(
    parameter int BANDS = 6,
    parameter int PIX_W = 7,
    parameter int SUM_W = 26,
    parameter int XP_W  = 34,
    parameter int CNT_W = 19,
    parameter int NPAIR = 21
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    vld_i,
    input logic                    last_i,
    input logic [BANDS*PIX_W-1:0]  pix_i,
    input logic [BANDS*SUM_W-1:0]  sum_o,
    input logic [NPAIR*XP_W-1:0]   xp_o,
    input logic [CNT_W-1:0]        cnt_o,
    input logic                    done_o
);

    logic [1:0] age;

    // Cycles since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(vld_i, 2) && !$past(start_i))
        |-> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !$past(vld_i, 2) && !$past(start_i))
        |-> ($stable(cnt_o) && $stable(sum_o) && $stable(xp_o))); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (age >= 2'd2 && $past(vld_i && last_i, 2))); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == '0 && sum_o == '0 && xp_o == '0)); // R8

    AST_DONE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o); // R9

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !$past(vld_i, 2)) |-> !done_o); // R4

endmodule

bind mbstat_accum mbstat_accum_chk #(
    .BANDS (BANDS),
    .PIX_W (PIX_W),
    .SUM_W (SUM_W),
    .XP_W  (XP_W),
    .CNT_W (CNT_W),
    .NPAIR (NPAIR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .vld_i   (vld_i),
    .last_i  (last_i),
    .pix_i   (pix_i),
    .sum_o   (sum_o),
    .xp_o    (xp_o),
    .cnt_o   (cnt_o),
    .done_o  (done_o)
);

// File: tb/mbstat_accum_bench.sv
// Directed bench for mbstat_accum: one task per scenario, each self-checking
// against a reference model built from the requirements.
module mbstat_accum_bench;

    localparam int BANDS = 6;
    localparam int PIX_W = 7;
    localparam int SUM_W = 26;
    localparam int XP_W  = 34;
    localparam int CNT_W = 19;
    localparam int NPAIR = BANDS * (BANDS + 1) / 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic                    vld_i = 1'b0;
    logic                    last_i = 1'b0;
    logic [BANDS*PIX_W-1:0]  pix_i = '0;
    logic [BANDS*SUM_W-1:0]  sum_o;
    logic [NPAIR*XP_W-1:0]   xp_o;
    logic [CNT_W-1:0]        cnt_o;
    logic                    done_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    longint ref_sum [BANDS];
    longint ref_xp [NPAIR];
    longint ref_cnt;

    always #4 clk = ~clk;

    mbstat_accum u_mbstat_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .vld_i   (vld_i),
        .last_i  (last_i),
        .pix_i   (pix_i),
        .sum_o   (sum_o),
        .xp_o    (xp_o),
        .cnt_o   (cnt_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int b = 0; b < BANDS; b++) ref_sum[b] = 0;
        for (int k = 0; k < NPAIR; k++) ref_xp[k] = 0;
        ref_cnt = 0;
    endtask

    // Drive one cycle of inputs (called right after a negedge) and update the model.
    task automatic apply(input bit st, input bit v, input bit l,
                         input logic [BANDS*PIX_W-1:0] px);
        start_i = st;
        vld_i   = v;
        last_i  = l;
        pix_i   = px;
        if (st) model_clear();
        if (v) begin
            int k;
            k = 0;
            for (int i = 0; i < BANDS; i++) begin
                ref_sum[i] += px[i*PIX_W +: PIX_W];
                for (int j = i; j < BANDS; j++) begin
                    ref_xp[k] += longint'(px[i*PIX_W +: PIX_W]) * longint'(px[j*PIX_W +: PIX_W]);
                    k++;
                end
            end
            ref_cnt++;
        end
    endtask

    task automatic idle_garbage();
        apply(1'b0, 1'b0, 1'b1, BANDS*PIX_W'($urandom));
    endtask

    function automatic logic [BANDS*PIX_W-1:0] rand_pix();
        logic [BANDS*PIX_W-1:0] p;
        for (int b = 0; b < BANDS; b++) p[b*PIX_W +: PIX_W] = PIX_W'($urandom);
        return p;
    endfunction

    task automatic check_state(input string req);
        for (int b = 0; b < BANDS; b++)
            check(sum_o[b*SUM_W +: SUM_W] == SUM_W'(ref_sum[b]), req, $sformatf("sum[%0d]", b),
                  longint'(sum_o[b*SUM_W +: SUM_W]), ref_sum[b]);
        for (int k = 0; k < NPAIR; k++)
            check(xp_o[k*XP_W +: XP_W] == XP_W'(ref_xp[k]), req, $sformatf("xp[%0d]", k),
                  longint'(xp_o[k*XP_W +: XP_W]), ref_xp[k]);
        check(cnt_o == CNT_W'(ref_cnt), req, "cnt", longint'(cnt_o), ref_cnt);
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        model_clear();
        check_state("R1");
        check(done_o == 1'b0, "R1", "done", longint'(done_o), 0);
    endtask

    // R2/R3/R6: single-beat frame with known pixels (band b carries b+1).
    task automatic t_single();
        logic [BANDS*PIX_W-1:0] px;
        for (int b = 0; b < BANDS; b++) px[b*PIX_W +: PIX_W] = PIX_W'(b + 1);
        @(negedge clk); apply(1'b1, 1'b1, 1'b1, px);
        @(negedge clk); apply(1'b0, 1'b0, 1'b0, '0);
        check(done_o == 1'b0, "R6", "done early", longint'(done_o), 0);
        @(negedge clk);
        check(done_o == 1'b1, "R6", "done", longint'(done_o), 1);
        check(sum_o[3*SUM_W +: SUM_W] == 4, "R2", "sum band3", longint'(sum_o[3*SUM_W +: SUM_W]), 4);
        check(xp_o[1*XP_W +: XP_W] == 2, "R2", "xp(0,1)", longint'(xp_o[1*XP_W +: XP_W]), 2);
        check(xp_o[6*XP_W +: XP_W] == 4, "R2", "xp(1,1)", longint'(xp_o[6*XP_W +: XP_W]), 4);
        check(xp_o[20*XP_W +: XP_W] == 36, "R2", "xp(5,5)", longint'(xp_o[20*XP_W +: XP_W]), 36);
        check_state("R3");
        @(negedge clk);
        check(done_o == 1'b0, "R6", "done width", longint'(done_o), 0);
    endtask

    // R5: back-to-back random beats.
    task automatic t_burst();
        for (int n = 0; n < 200; n++) begin
            @(negedge clk); apply(n == 0, 1'b1, n == 199, rand_pix());
        end
        @(negedge clk); apply(1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        check(done_o == 1'b1, "R5", "done", longint'(done_o), 1);
        check_state("R5");
    endtask

    // R4: random gaps with garbage pixels and last while valid is low.
    task automatic t_gaps();
        int early;
        early = 0;
        @(negedge clk); apply(1'b1, 1'b1, 1'b0, rand_pix());
        for (int n = 1; n < 150; n++) begin
            int gap;
            gap = $urandom_range(0, 3);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (done_o) early++;
                idle_garbage();
            end
            @(negedge clk);
            if (done_o) early++;
            apply(1'b0, 1'b1, n == 149, rand_pix());
        end
        @(negedge clk); idle_garbage();
        check(done_o == 1'b0 && early == 0, "R4", "spurious done", longint'(early), 0);
        @(negedge clk); idle_garbage();
        check(done_o == 1'b1, "R6", "done after gaps", longint'(done_o), 1);
        check_state("R4");
    endtask

    // R7: long idle after done leaves outputs unchanged.
    task automatic t_hold();
        for (int n = 0; n < 20; n++) begin
            @(negedge clk); idle_garbage();
        end
        @(negedge clk); apply(1'b0, 1'b0, 1'b0, '0);
        check(done_o == 1'b0, "R7", "done idle", longint'(done_o), 0);
        check_state("R7");
    endtask

    // R10: full-scale pixels over 4096 beats.
    task automatic t_max();
        logic [BANDS*PIX_W-1:0] px;
        px = '1;
        for (int n = 0; n < 4096; n++) begin
            @(negedge clk); apply(n == 0, 1'b1, n == 4095, px);
        end
        @(negedge clk); apply(1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        check(sum_o[0 +: SUM_W] == 520192, "R10", "sum full", longint'(sum_o[0 +: SUM_W]), 520192);
        check(xp_o[10*XP_W +: XP_W] == 66064384, "R10", "xp full",
              longint'(xp_o[10*XP_W +: XP_W]), 66064384);
        check_state("R10");
    endtask

    // R8: start with a beat exactly in the done cycle.
    task automatic t_start_in_done();
        logic [BANDS*PIX_W-1:0] px;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk); apply(n == 0, 1'b1, n == 4, rand_pix());
        end
        @(negedge clk); apply(1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        check(done_o == 1'b1, "R8", "done before restart", longint'(done_o), 1);
        check_state("R8");
        px = rand_pix();
        apply(1'b1, 1'b1, 1'b1, px);
        @(negedge clk); apply(1'b0, 1'b0, 1'b0, '0);
        check(cnt_o == 0, "R8", "cleared", longint'(cnt_o), 0);
        @(negedge clk);
        check(done_o == 1'b1, "R8", "done new frame", longint'(done_o), 1);
        check(cnt_o == 1, "R8", "cnt new frame", longint'(cnt_o), 1);
        check_state("R8");
    endtask

    // R9: start one cycle after last cancels the frame end.
    task automatic t_cancel();
        int seen;
        seen = 0;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk); apply(n == 0, 1'b1, n == 4, rand_pix());
        end
        @(negedge clk); apply(1'b1, 1'b0, 1'b0, '0);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk); apply(1'b0, 1'b0, 1'b0, '0);
            if (done_o) seen++;
        end
        check(seen == 0, "R9", "done count", longint'(seen), 0);
        check(cnt_o == 0, "R9", "cnt", longint'(cnt_o), 0);
        check_state("R9");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        model_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_gaps();
        t_hold();
        t_max();
        t_start_in_done();
        t_cancel();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

endmodule